// File: doc/BRIEF.md
# Sector DMA Engine with CPU Cycle Stealing

This block moves one 512-byte sector between the 16-bit data port of an IDE disk and system RAM. It does this without CPU copy loops: it takes single bus cycles away from a 6502-style processor. The CPU first sends the drive its command as ordinary 8-bit programmed I/O. It then writes a starting word address and a direction into the engine and sets the start bit. From that point the engine waits for the drive to raise its DMA request line.

Bus takeover is tied to the processor clock. The engine samples PHI2, and only on a falling edge of PHI2 does it pull the CPU's bus-enable and ready lines low and answer the drive with its active-low acknowledge. In the next system clock it moves one word. A single strobe pair carries that word between the drive and RAM, and the word address then advances. The engine keeps the bus while the drive holds its request, and takes one more word on each later PHI2 fall. If the drive withdraws its request, the engine gives the bus back and keeps its count, then continues from there when the request returns.

After word 256 the engine releases everything and raises an interrupt, which stays up until the CPU clears it. While a sector is in flight, the programmed-I/O strobes toward the drive are held inactive. In the PHI2 that follows a stolen cycle, the CPU cannot reach the engine's registers or the drive's programmed-I/O port.

Top module: `ide_dma_steal`

## Requirements
- R1: After reset, cpu_be, cpu_rdy, ide_dmack_n, ide_drd_n and ide_dwr_n are high, and mem_rd, mem_wr and irq are low.
- R2: A control write (cpu_addr 0) with bit 0 set arms the engine while it is idle, and bit 1 selects the direction (0 = drive to RAM, 1 = RAM to drive). While armed, the bus stays with the CPU until ide_dmarq is high. cpu_be, cpu_rdy and ide_dmack_n go low only in the clock that follows a sampled falling edge of phi2.
- R3: Each stolen cycle moves one word during exactly one clock, the first clock after the phi2 fall. Toward RAM, ide_drd_n is low, mem_wr is high and mem_wdata equals ide_rdata. Toward the drive, mem_rd is high, ide_dwr_n is low and ide_wdata equals mem_rdata. At most one word moves per phi2 period.
- R4: The first word uses the word address written to registers 1 (bits 7:0) and 2 (upper bits). Each later word uses the next address, modulo 2^AW.
- R5: After exactly 256 words the engine returns cpu_be, cpu_rdy and ide_dmack_n high and sets irq. The control read shows bit 7 = done, bit 6 = busy and bit 1 = direction.
- R6: irq stays set until a control write with bit 7 set clears it.
- R7: If ide_dmarq is low while the engine holds the bus, the bus and acknowledge are released within two clocks and no word moves. When the request returns, the transfer resumes at the next untransferred word.
- R8: While the engine is busy, ide_cs_n, ide_ior_n and ide_iow_n stay high. Otherwise they follow pio_cs_n, pio_rd_n and pio_wr_n.
- R9: From a stolen cycle until the next sampled phi2 fall, CPU register writes are ignored, register reads return 0 and the programmed-I/O strobes stay high.
- R10: A start write while the engine is busy has no effect on direction, address or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several periods per phi2 cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | CPU phase-2 clock level |
| cpu_sel | input | 1 | CPU access to the engine's registers |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 2 | Register select: 0 control/status, 1 address low, 2 address high, 3 word count |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| cpu_be | output | 1 | CPU bus enable, low while the bus is stolen |
| cpu_rdy | output | 1 | CPU ready, low while the bus is stolen |
| irq | output | 1 | Sector-done interrupt |
| pio_cs_n | input | 2 | CPU-side programmed-I/O chip selects |
| pio_rd_n | input | 1 | CPU-side programmed-I/O read strobe |
| pio_wr_n | input | 1 | CPU-side programmed-I/O write strobe |
| ide_cs_n | output | 2 | Chip selects to the drive |
| ide_ior_n | output | 1 | Programmed-I/O read strobe to the drive |
| ide_iow_n | output | 1 | Programmed-I/O write strobe to the drive |
| ide_dmarq | input | 1 | DMA request from the drive |
| ide_dmack_n | output | 1 | DMA acknowledge to the drive, active low |
| ide_drd_n | output | 1 | DMA word read strobe to the drive |
| ide_dwr_n | output | 1 | DMA word write strobe to the drive |
| ide_rdata | input | 16 | Word from the drive |
| ide_wdata | output | 16 | Word to the drive |
| mem_addr | output | AW | RAM word address |
| mem_rd | output | 1 | RAM read strobe |
| mem_wr | output | 1 | RAM write strobe |
| mem_rdata | input | 16 | Word read from RAM |
| mem_wdata | output | 16 | Word written to RAM |

## Verification
The bench runs full sectors over a grid of both directions, three start addresses and two request patterns. One start address is zero, one lies mid-space and one sits just below the top of the address space, so a wrong increment or a missing wrap shows up as an address mismatch. Drive words are made from the word index and RAM words from the address, so a skipped, repeated or reversed word gives a different value. The request pattern either stays steady or drops every 37 words. The dropping pattern separates a correct resume from a restart or a lost word. A start write issued during each pause confirms that a busy engine ignores a second start. Every word strobe and every takeover is also checked against the phi2 phase, and the lockout window after the last stolen cycle is probed with a register write, a status read and a programmed-I/O read.

// File: rtl/ide_dma_pkg.sv
// Package: shared types and register indices for the sector DMA engine.
// Assumes: nothing beyond standard SystemVerilog.
package ide_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    typedef enum logic {
        DIR_TO_MEM = 1'b0,
        DIR_TO_DEV = 1'b1
    } xfer_dir_t;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_ALO  = 2'd1;
    localparam logic [1:0] RA_AHI  = 2'd2;
    localparam logic [1:0] RA_CNT  = 2'd3;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_CLEAR = 7;
endpackage

// File: rtl/dma_phase.sv
// Module: dma_phase
// Detects the falling edge of phi2 in the system clock domain and keeps the
// CPU lockout window that follows each stolen cycle.
// Assumes: phi2 is synchronous to clk and stays in each level for at least
// one clk period.
module dma_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic xfer_act,
    output logic phi2_fall,
    output logic lock_tail
);
    logic phi2_q;

    // Register phi2 so that a high-to-low change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2;
    end

    assign phi2_fall = phi2_q & ~phi2;

    // Hold the lockout from a stolen cycle until the next phi2 fall.
    always_ff @(posedge clk) begin
        if (!rst_n)         lock_tail <= 1'b0;
        else if (xfer_act)  lock_tail <= 1'b1;
        else if (phi2_fall) lock_tail <= 1'b0;
    end

    AST_TAIL_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_act |=> lock_tail) else $error("lockout missing after stolen cycle"); // R9
endmodule

// File: rtl/dma_walk.sv
// Module: dma_walk
// Holds the word address and the word counter of a sector transfer.
// Assumes: load and step are never asserted in the same cycle.
module dma_walk #(
    parameter int AW    = 16,
    parameter int WORDS = 256,
    localparam int CW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count,
    output logic          last
);
    localparam logic [CW-1:0] LAST_CNT = CW'(WORDS - 1);

    // Load the start address, then advance address and count per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            count <= '0;
        end else if (load) begin
            addr  <= base;
            count <= '0;
        end else if (step) begin
            addr  <= addr + 1'b1;
            count <= count + 1'b1;
        end
    end

    assign last = (count == LAST_CNT);
endmodule

// File: rtl/dma_seq.sv
// Module: dma_seq
// Sequencer that arms on a start, waits for the drive's request, takes the
// bus on a phi2 fall, moves one word per stolen cycle, pauses when the
// request drops and finishes after the last word.
// Assumes: phi2_fall is a one-clock pulse.
module dma_seq
    import ide_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dmarq,
    input  logic phi2_fall,
    input  logic last,
    output logic own,
    output logic xfer,
    output logic busy,
    output logic done_set
);
    seq_state_t state_q, state_d;

    // Choose the next sequencer state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ARMED;
            ST_ARMED: if (dmarq && phi2_fall) state_d = ST_XFER;
            ST_XFER:  state_d = last ? ST_IDLE : ST_HOLD;
            ST_HOLD: begin
                if (!dmarq)         state_d = ST_ARMED;
                else if (phi2_fall) state_d = ST_XFER;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign own      = (state_q == ST_XFER) || (state_q == ST_HOLD);
    assign xfer     = (state_q == ST_XFER);
    assign busy     = (state_q != ST_IDLE);
    assign done_set = xfer && last;

    AST_TAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own) |-> $past(phi2_fall)) else $error("bus taken off phi2 fall"); // R2
    AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer) else $error("two words in a row"); // R3
    AST_REQ_BEFORE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer) |-> $past(dmarq)) else $error("word without request"); // R7
    AST_PAUSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !dmarq) |=> !own) else $error("bus kept after request drop"); // R7
endmodule

// File: rtl/dma_regs.sv
// Module: dma_regs
// CPU register file (control, start address, count) with done flag,
// lockout gating of CPU accesses and gating of the programmed-I/O strobes.
// Assumes: AW is between 9 and 16; reads are combinational.
module dma_regs
    import ide_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_sel,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    input  logic          blocked,
    input  logic          busy,
    input  logic          done_set,
    input  logic [CW-1:0] count,
    input  logic [1:0]    pio_cs_n,
    input  logic          pio_rd_n,
    input  logic          pio_wr_n,
    output logic [1:0]    ide_cs_n,
    output logic          ide_ior_n,
    output logic          ide_iow_n,
    output logic          start,
    output xfer_dir_t     dir,
    output logic [AW-1:0] base,
    output logic          irq
);
    logic acc_ok, wr_ok, clr_done, quiet;

    assign acc_ok   = cpu_sel && !blocked;
    assign wr_ok    = acc_ok && cpu_we;
    assign start    = wr_ok && (cpu_addr == RA_CTRL) && cpu_wdata[CB_START] && !busy;
    assign clr_done = wr_ok && (cpu_addr == RA_CTRL) && cpu_wdata[CB_CLEAR];

    // Start address registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (wr_ok && !busy) begin
            if (cpu_addr == RA_ALO) base[7:0]    <= cpu_wdata;
            if (cpu_addr == RA_AHI) base[AW-1:8] <= cpu_wdata[AW-9:0];
        end
    end

    // Direction is captured with an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)     dir <= DIR_TO_MEM;
        else if (start) dir <= xfer_dir_t'(cpu_wdata[CB_DIR]);
    end

    // Done flag: set by the last word, cleared by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (done_set) irq <= 1'b1;
        else if (clr_done) irq <= 1'b0;
    end

    // Register read mux; blocked reads return zero.
    always_comb begin
        cpu_rdata = 8'h00;
        if (acc_ok && !cpu_we) begin
            unique case (cpu_addr)
                RA_CTRL: cpu_rdata = {irq, busy, 4'b0000, dir, 1'b0};
                RA_ALO:  cpu_rdata = base[7:0];
                RA_AHI:  cpu_rdata = 8'(base[AW-1:8]);
                RA_CNT:  cpu_rdata = 8'(count);
                default: cpu_rdata = 8'h00;
            endcase
        end
    end

    // Programmed-I/O strobes pass through unless a transfer or lockout holds them.
    assign quiet     = busy || blocked;
    assign ide_cs_n  = quiet ? 2'b11 : pio_cs_n;
    assign ide_ior_n = quiet ? 1'b1  : pio_rd_n;
    assign ide_iow_n = quiet ? 1'b1  : pio_wr_n;

    AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_we && blocked) |=> $stable(base)) else $error("blocked write landed"); // R9
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cpu_sel && cpu_we && cpu_addr == RA_CTRL && cpu_wdata[CB_CLEAR])) |=> irq)
        else $error("irq dropped without clear"); // R6
endmodule

// File: rtl/ide_dma_steal.sv
// Module: ide_dma_steal (top)
// Sector DMA engine that steals CPU bus cycles on phi2 falls and moves
// 16-bit words between an IDE drive's data port and RAM.
// Assumes: RAM read data is valid in the same clock as mem_rd; the drive
// presents and accepts data within the strobe clock.
module ide_dma_steal
    import ide_dma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int WORDS = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phi2,
    input  logic          cpu_sel,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    output logic          cpu_be,
    output logic          cpu_rdy,
    output logic          irq,
    input  logic [1:0]    pio_cs_n,
    input  logic          pio_rd_n,
    input  logic          pio_wr_n,
    output logic [1:0]    ide_cs_n,
    output logic          ide_ior_n,
    output logic          ide_iow_n,
    input  logic          ide_dmarq,
    output logic          ide_dmack_n,
    output logic          ide_drd_n,
    output logic          ide_dwr_n,
    input  logic [15:0]   ide_rdata,
    output logic [15:0]   ide_wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   mem_wdata
);
    localparam int CW = $clog2(WORDS);

    logic          phi2_fall, lock_tail, own, xfer, busy, done_set, last, start;
    logic [CW-1:0] count;
    logic [AW-1:0] base;
    xfer_dir_t     dir;

    dma_phase u_phase (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .xfer_act(xfer),
        .phi2_fall(phi2_fall), .lock_tail(lock_tail)
    );

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dmarq(ide_dmarq),
        .phi2_fall(phi2_fall), .last(last), .own(own), .xfer(xfer),
        .busy(busy), .done_set(done_set)
    );

    dma_walk #(.AW(AW), .WORDS(WORDS)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(start), .base(base), .step(xfer),
        .addr(mem_addr), .count(count), .last(last)
    );

    dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .blocked(own || lock_tail), .busy(busy), .done_set(done_set),
        .count(count), .pio_cs_n(pio_cs_n), .pio_rd_n(pio_rd_n),
        .pio_wr_n(pio_wr_n), .ide_cs_n(ide_cs_n), .ide_ior_n(ide_ior_n),
        .ide_iow_n(ide_iow_n), .start(start), .dir(dir), .base(base), .irq(irq)
    );

    // Bus ownership and word strobes.
    assign cpu_be      = ~own;
    assign cpu_rdy     = ~own;
    assign ide_dmack_n = ~own;
    assign mem_wr      = xfer && (dir == DIR_TO_MEM);
    assign mem_rd      = xfer && (dir == DIR_TO_DEV);
    assign ide_drd_n   = ~mem_wr;
    assign ide_dwr_n   = ~mem_rd;
    assign mem_wdata   = ide_rdata;
    assign ide_wdata   = mem_rdata;

    AST_PIO_QUIET_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_dmack_n |-> (ide_ior_n && ide_iow_n && ide_cs_n == 2'b11))
        else $error("pio strobe during dma"); // R8
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cpu_be && cpu_rdy && ide_dmack_n)) else $error("bus held at done"); // R5
endmodule

// File: tb/sim_ide_dma_steal.sv
module sim_ide_dma_steal;
    localparam int AW = 16;
    localparam int WORDS = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pc = 2'd0;
    logic phi2;
    logic cpu_sel = 0, cpu_we = 0;
    logic [1:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;
    logic cpu_be, cpu_rdy, irq;
    logic [1:0] pio_cs_n = 2'b11;
    logic pio_rd_n = 1, pio_wr_n = 1;
    logic [1:0] ide_cs_n;
    logic ide_ior_n, ide_iow_n, ide_dmack_n, ide_drd_n, ide_dwr_n;
    logic ide_dmarq = 0;
    logic [15:0] ide_rdata, ide_wdata, mem_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic mem_rd, mem_wr;

    int total = 0, bad = 0, cycles = 0, wcnt = 0;
    logic [AW-1:0] mon_base = 0;
    logic mon_dir = 0;
    logic be_prev = 1'b1;

    always #10 clk = ~clk;

    // phi2: two clocks high, two low, changing 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        pc = pc + 2'd1;
    end
    assign phi2 = (pc < 2'd2);

    assign ide_rdata = 16'hC3A5 ^ (16'(wcnt) * 16'h0101);
    assign mem_rdata = mem_addr * 16'd7 + 16'd3;

    ide_dma_steal #(.AW(AW), .WORDS(WORDS)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Word monitor: every strobe checked for phase, address, data, polarity.
    always @(negedge clk) begin
        if (rst_n) begin
            if (be_prev && !cpu_be)
                chk(pc == 2'd3, "R2 takeover phase", pc, 3);
            be_prev = cpu_be;
            if (mem_wr || mem_rd) begin
                logic [AW-1:0] ea;
                ea = mon_base + AW'(wcnt);
                chk(pc == 2'd3, "R3 strobe phase", pc, 3);
                chk(mem_addr == ea, "R4 R10 address", mem_addr, ea);
                if (mon_dir == 1'b0)
                    chk(mem_wr && !mem_rd && !ide_drd_n && ide_dwr_n &&
                        mem_wdata == (16'hC3A5 ^ (16'(wcnt) * 16'h0101)),
                        "R3 R10 to-mem word", mem_wdata, 16'hC3A5 ^ (16'(wcnt) * 16'h0101));
                else
                    chk(mem_rd && !mem_wr && !ide_dwr_n && ide_drd_n &&
                        ide_wdata == ea * 16'd7 + 16'd3,
                        "R3 R10 to-dev word", ide_wdata, ea * 16'd7 + 16'd3);
                wcnt++;
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        cpu_sel = 1; cpu_we = 0; cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_sel = 0;
    endtask

    task automatic run(input logic dir, input logic [AW-1:0] base, input int pause_every);
        logic [7:0] rd;
        int guard, last_pause, hold;
        cpu_write(2'd1, base[7:0]);
        cpu_write(2'd2, base[15:8]);
        mon_base = base; mon_dir = dir; wcnt = 0;
        cpu_write(2'd0, {6'd0, dir, 1'b1});
        repeat (8) tick();
        cpu_read(2'd0, rd);
        chk(cpu_be && cpu_rdy && ide_dmack_n && rd[6], "R2 armed waits for request",
            {cpu_be, ide_dmack_n, rd[6]}, 3'b111);
        pio_wr_n = 0; pio_cs_n = 2'b10; #1;
        chk(ide_iow_n && ide_cs_n == 2'b11, "R8 pio held while busy", {ide_iow_n, ide_cs_n}, 3'b111);
        pio_wr_n = 1; pio_cs_n = 2'b11;
        ide_dmarq = 1;
        guard = 0; last_pause = 0;
        while (!irq && guard < 5000) begin
            tick();
            guard++;
            if (pause_every != 0 && wcnt != 0 && wcnt % pause_every == 0 &&
                wcnt != last_pause && wcnt < WORDS - 1 && !irq) begin
                last_pause = wcnt;
                ide_dmarq = 0;
                tick(); tick();
                chk(cpu_be && cpu_rdy && ide_dmack_n, "R7 release on request drop",
                    {cpu_be, ide_dmack_n}, 2'b11);
                hold = wcnt;
                repeat (12) tick();
                cpu_write(2'd0, {6'd0, ~dir, 1'b1});
                cpu_write(2'd1, 8'h5C);
                repeat (4) tick();
                chk(wcnt == hold, "R7 no word while paused", wcnt, hold);
                ide_dmarq = 1;
            end
        end
        chk(wcnt == WORDS && irq && cpu_be && cpu_rdy && ide_dmack_n, "R5 sector complete",
            wcnt, WORDS);
        ide_dmarq = 0;
        // Lockout window right after the final stolen cycle.
        cpu_read(2'd0, rd);
        chk(rd == 8'h00, "R9 read blocked", rd, 0);
        pio_rd_n = 0; #1;
        chk(ide_ior_n == 1'b1, "R9 pio blocked", ide_ior_n, 1);
        pio_rd_n = 1;
        cpu_write(2'd1, 8'h77);
        repeat (8) tick();
        cpu_read(2'd1, rd);
        chk(rd == base[7:0], "R9 write ignored", rd, base[7:0]);
        cpu_read(2'd0, rd);
        chk(rd == {1'b1, 1'b0, 4'd0, dir, 1'b0}, "R5 status", rd, {1'b1, 1'b0, 4'd0, dir, 1'b0});
        pio_rd_n = 0; pio_cs_n = 2'b01; #1;
        chk(ide_ior_n == 1'b0 && ide_cs_n == 2'b01, "R8 pio follows", {ide_ior_n, ide_cs_n}, 3'b001);
        pio_rd_n = 1; pio_cs_n = 2'b11;
        repeat (20) tick();
        chk(irq == 1'b1, "R6 irq held", irq, 1);
        cpu_write(2'd0, 8'h80);
        chk(irq == 1'b0, "R6 irq cleared", irq, 0);
    endtask

    initial begin
        logic [AW-1:0] bases [3];
        bases[0] = 16'h0000; bases[1] = 16'h1234; bases[2] = 16'hFFF0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        tick();
        chk(cpu_be && cpu_rdy && ide_dmack_n && ide_drd_n && ide_dwr_n &&
            !mem_rd && !mem_wr && !irq, "R1 reset state",
            {cpu_be, cpu_rdy, ide_dmack_n, ide_drd_n, ide_dwr_n, mem_rd, mem_wr, irq}, 8'hF8);
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 3; b++)
                for (int p = 0; p < 2; p++)
                    run(d[0], bases[b], p == 0 ? 0 : 37);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule